// File: doc/BRIEF.md
# Non-Volatile Program/Erase Sequencer

This block sequences program and erase operations on a 768-byte non-volatile array that is organised as 16-bit words. Software first sets a latch bit in the control register and then writes an address and data into the array window, which captures the target. It then chooses program or erase and the erase size, and finally sets the program-enable bit. While that bit is set and stop mode is not active, the block raises a high-voltage enable and counts a pulse time taken from a reload register. When the count runs out, it applies the result to a modelled byte array and clears the program-enable bit.

Programming can only clear bits. A programmed byte becomes the AND of its old value and the new data. Erasing sets bytes to 0xFF. Erase can cover a byte, an aligned word, a 32-byte row or the whole array. A word request at an odd address falls back to the single byte at that address.

Stop mode drops the high voltage at once and freezes the pulse count. The program-enable bit stays set, so the operation resumes by itself when stop mode ends. Wait mode has no pin of its own because the operation simply continues through it.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, and hv_en, pgm_on and op_done are low.
- R2: A control write with bit 0 (enable) set raises pgm_on only if three things hold. The stored latch bit is set, an in-range address has been captured since that bit was last set, and the same write keeps bit 1 (latch) set. Otherwise pgm_on stays low.
- R3: While pgm_on is high, array-window writes are ignored, and so are the latch, erase (bit 2) and size (bits 4:3) fields of control writes.
- R4: A program operation replaces the byte with old AND data[7:0].
- R5: A word program at an even address writes data[7:0] to that address and data[15:8] to the next address.
- R6: A word request at an odd address affects only the addressed byte, using data[7:0]. The byte after it is untouched.
- R7: With reload value T and no stop, hv_en is high for T+1 cycles. The array update and the op_done pulse appear together in the cycle after the last high cycle, and pgm_on is low from then on.
- R8: Byte erase (size 0) sets the addressed byte to 0xFF. Word erase (size 1) at an even address sets that byte and the next one.
- R9: Row erase (size 2) sets to 0xFF the 32 bytes whose address matches the captured address when bits 4:0 are ignored, and no others.
- R10: Bulk erase (size 3) sets all 768 bytes to 0xFF.
- R11: While stop_in is high, hv_en is low in the same cycle, the pulse count holds and pgm_on stays set. When stop_in falls, the operation resumes with the same total of T+1 high cycles.
- R12: Clearing bit 0 of the control register while pgm_on is high aborts the operation. hv_en and pgm_on fall, no op_done appears and the array is unchanged.
- R13: Array-window writes to addresses of 768 or more are not captured. Reads at such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the pulse reload register |
| reg_wdata | input | 16 | Register write data |
| arr_wr | input | 1 | Array-window write strobe (captures the target) |
| arr_addr | input | 10 | Byte address of the array-window write |
| arr_word | input | 1 | 1 requests a word, 0 requests a byte |
| arr_wdata | input | 16 | Array-window write data |
| stop_in | input | 1 | Stop mode active |
| rd_addr | input | 10 | Read byte address |
| rd_data | output | 8 | Byte read from the array |
| hv_en | output | 1 | High-voltage enable |
| pgm_on | output | 1 | Program-enable bit |
| op_done | output | 1 | One-cycle pulse when the array has been updated |

## Verification
A wrong captured target or a wrong erase size shows at rd_data in the same cycle that op_done pulses. The affected bytes and their neighbours then disagree with a value that has been ANDed or filled with 0xFF independently. A wrong pulse count shows as a different number of hv_en cycles before op_done. A stuck or leaking stop gate shows as hv_en high during stop, or as pgm_on falling there, within one cycle. An interlock fault appears at once, as pgm_on rising after a control write that should have been refused.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

  localparam int unsigned NVM_BYTES = 768;
  localparam int unsigned NVM_ROW   = 32;
  localparam int unsigned NVM_TW    = 16;

  typedef enum logic [1:0] {
    ER_BYTE = 2'd0,
    ER_WORD = 2'd1,
    ER_ROW  = 2'd2,
    ER_BULK = 2'd3
  } er_size_e;

  // Does the operation on the captured target touch byte idx?
  function automatic logic hit_byte(input int idx, input int base, input logic erase,
                                    input er_size_e sz, input logic two, input int row_bytes);
    logic h;
    if (erase) begin
      case (sz)
        ER_BYTE: h = (idx == base);
        ER_WORD: h = (idx == base) || ((base % 2 == 0) && (idx == base + 1));
        ER_ROW:  h = (idx / row_bytes) == (base / row_bytes);
        default: h = 1'b1;
      endcase
    end else begin
      h = (idx == base) || (two && (idx == base + 1));
    end
    return h;
  endfunction

  // Programming can only clear bits; erasing fills with ones.
  function automatic logic [7:0] next_byte(input logic [7:0] old, input logic erase,
                                           input logic [7:0] data);
    return erase ? 8'hFF : (old & data);
  endfunction

endpackage

// File: rtl/nvm_pe_regs.sv
module nvm_pe_regs
  import nvm_pe_pkg::*;
#(
  parameter int unsigned N_BYTES = NVM_BYTES,
  parameter int unsigned TW      = NVM_TW,
  localparam int unsigned AW     = $clog2(N_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [TW-1:0] reg_wdata,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic          arr_word,
  input  logic [15:0]   arr_wdata,
  input  logic          expire,
  output logic          pgm_en,
  output logic          arm,
  output logic          lat_valid,
  output logic [TW-1:0] reload,
  output logic [AW-1:0] lat_addr,
  output logic [15:0]   lat_data,
  output logic          lat_two,
  output logic          is_erase,
  output er_size_e      esize
);

  logic latch_en;
  logic ctrl_wr, tim_wr, cap;

  assign ctrl_wr = reg_wr && !reg_sel;
  assign tim_wr  = reg_wr && reg_sel;
  assign cap     = arr_wr && latch_en && !pgm_en && (int'(arr_addr) < int'(N_BYTES));
  // Interlock: target captured under the latch bit, and the latch bit kept.
  assign arm     = ctrl_wr && !pgm_en && reg_wdata[0] && reg_wdata[1] && latch_en && lat_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_en    <= 1'b0;
      latch_en  <= 1'b0;
      is_erase  <= 1'b0;
      esize     <= ER_BYTE;
      lat_valid <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
      lat_two   <= 1'b0;
      reload    <= '0;
    end else begin
      if (cap) begin
        lat_valid <= 1'b1;
        lat_addr  <= arr_addr;
        lat_data  <= arr_wdata;
        lat_two   <= arr_word && !arr_addr[0];
      end
      if (expire) pgm_en <= 1'b0;
      if (ctrl_wr) begin
        if (pgm_en) begin
          if (!reg_wdata[0]) pgm_en <= 1'b0;
        end else begin
          latch_en <= reg_wdata[1];
          is_erase <= reg_wdata[2];
          esize    <= er_size_e'(reg_wdata[4:3]);
          if (!reg_wdata[1]) lat_valid <= 1'b0;
          if (arm) pgm_en <= 1'b1;
        end
      end
      if (tim_wr) reload <= reg_wdata;
    end
  end

endmodule

// File: rtl/nvm_pe_timer.sv
module nvm_pe_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_en,
  input  logic          arm,
  input  logic          stop_in,
  input  logic [TW-1:0] reload,
  output logic          hv_en,
  output logic          expire
);

  logic [TW-1:0] cnt;

  assign hv_en  = pgm_en && !stop_in;
  assign expire = hv_en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (arm)                  cnt <= reload;
    else if (hv_en && cnt != '0)   cnt <= cnt - TW'(1);
  end

endmodule

// File: rtl/nvm_pe_array.sv
module nvm_pe_array
  import nvm_pe_pkg::*;
#(
  parameter int unsigned N_BYTES = NVM_BYTES,
  parameter int unsigned ROW     = NVM_ROW,
  localparam int unsigned AW     = $clog2(N_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic [AW-1:0] lat_addr,
  input  logic [15:0]   lat_data,
  input  logic          lat_two,
  input  logic          is_erase,
  input  er_size_e      esize,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [N_BYTES];

  for (genvar g = 0; g < int'(N_BYTES); g++) begin : g_byte
    logic       hit;
    logic [7:0] din;
    assign hit = hit_byte(g, int'(lat_addr), is_erase, esize, lat_two, int'(ROW));
    assign din = (g == int'(lat_addr)) ? lat_data[7:0] : lat_data[15:8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mem[g] <= 8'hFF;
      else if (apply && hit) mem[g] <= next_byte(mem[g], is_erase, din);
    end
  end

  assign rd_data = (int'(rd_addr) < int'(N_BYTES)) ? mem[rd_addr] : 8'h00;

endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
  import nvm_pe_pkg::*;
#(
  parameter int unsigned N_BYTES = NVM_BYTES,
  parameter int unsigned ROW     = NVM_ROW,
  parameter int unsigned TW      = NVM_TW,
  localparam int unsigned AW     = $clog2(N_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [TW-1:0] reg_wdata,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic          arr_word,
  input  logic [15:0]   arr_wdata,
  input  logic          stop_in,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          hv_en,
  output logic          pgm_on,
  output logic          op_done
);

  // Named internal events, visible to the bound checker.
  logic          arm;
  logic          expire;
  logic          lat_valid;
  logic          pgm_en;
  logic [TW-1:0] reload;
  logic [AW-1:0] lat_addr;
  logic [15:0]   lat_data;
  logic          lat_two;
  logic          is_erase;
  er_size_e      esize;

  nvm_pe_regs #(.N_BYTES(N_BYTES), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_word(arr_word), .arr_wdata(arr_wdata),
    .expire(expire), .pgm_en(pgm_en), .arm(arm), .lat_valid(lat_valid), .reload(reload),
    .lat_addr(lat_addr), .lat_data(lat_data), .lat_two(lat_two),
    .is_erase(is_erase), .esize(esize)
  );

  nvm_pe_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .arm(arm), .stop_in(stop_in),
    .reload(reload), .hv_en(hv_en), .expire(expire)
  );

  nvm_pe_array #(.N_BYTES(N_BYTES), .ROW(ROW)) u_array (
    .clk(clk), .rst_n(rst_n), .apply(expire), .lat_addr(lat_addr), .lat_data(lat_data),
    .lat_two(lat_two), .is_erase(is_erase), .esize(esize),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_done <= 1'b0;
    else        op_done <= expire;
  end

  assign pgm_on = pgm_en;

endmodule

// File: rtl/nvm_pe_ctrl_chk.sv
module nvm_pe_ctrl_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic          stop_in,
  input logic          hv_en,
  input logic          pgm_on,
  input logic          op_done,
  input logic          lat_valid,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);

  // R7: voltage only with the enable bit set
  p_hv_needs_pgm_r7: assert property (@(posedge clk) disable iff (!rst_n) hv_en |-> pgm_on);

  // R11: stop gates the voltage in the same cycle
  p_stop_blocks_hv_r11: assert property (@(posedge clk) disable iff (!rst_n) stop_in |-> !hv_en);

  // R11: stop leaves the enable bit set
  p_stop_keeps_pgm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_on && stop_in && !(reg_wr && !reg_sel)) |=> pgm_on);

  // R2: enable rises only after a target was captured
  p_arm_needs_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_on) |-> $past(lat_valid));

  // R7: completion follows a voltage cycle and clears the enable bit
  p_done_after_hv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (!pgm_on && $past(hv_en)));

  // R12: the array changes only together with a completion pulse
  p_quiet_array_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !op_done) |-> $stable(rd_data));

endmodule

bind nvm_pe_ctrl nvm_pe_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .stop_in(stop_in),
  .hv_en(hv_en), .pgm_on(pgm_on), .op_done(op_done), .lat_valid(lat_valid),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/nvm_pe_ctrl_tb.sv
module nvm_pe_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int NB    = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        arr_wr = 1'b0, arr_word = 1'b0;
  logic [9:0]  arr_addr = '0;
  logic [15:0] arr_wdata = '0;
  logic        stop_in = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        hv_en, pgm_on, op_done;

  int total = 0;
  int bad = 0;

  typedef struct { int addr; int val; string tag; } exp_t;
  exp_t q[$];
  logic [7:0] model [NB];

  always #(CLK_P/2) clk = ~clk;

  nvm_pe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_word(arr_word), .arr_wdata(arr_wdata),
    .stop_in(stop_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .hv_en(hv_en), .pgm_on(pgm_on), .op_done(op_done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected bytes and compares against the read port.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        rd_addr = 10'(it.addr);
        #1;
        check(it.tag, int'(rd_data), it.val);
      end
    end
  end

  task automatic expect_byte(input int a, input int v, input string tag);
    exp_t it;
    it.addr = a; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic arr_write(input int a, input logic [15:0] d, input logic w);
    @(negedge clk);
    arr_wr = 1'b1; arr_addr = 10'(a); arr_wdata = d; arr_word = w;
    @(negedge clk);
    arr_wr = 1'b0;
  endtask

  // control word: bit1 latch, bit2 erase, bits4:3 size, bit0 enable
  function automatic logic [15:0] ctrl(input logic en, input logic er, input int sz);
    return {11'd0, 2'(sz), er, 1'b1, en};
  endfunction

  task automatic arm_op(input int a, input logic [15:0] d, input logic w,
                        input logic er, input int sz, input int t, input string req);
    reg_write(1'b1, 16'(t));
    reg_write(1'b0, ctrl(1'b0, er, sz));
    arr_write(a, d, w);
    reg_write(1'b0, ctrl(1'b1, er, sz));
    #1;
    check({req, "/R2 armed"}, int'(pgm_on), 1);
  endtask

  task automatic wait_done(input int stop_at, input int stop_len, output int n);
    n = 0;
    for (int k = 0; k < 4000; k++) begin
      stop_in = (stop_at >= 0) && (k >= stop_at) && (k < stop_at + stop_len);
      #1;
      if (op_done) break;
      if (hv_en) n++;
      if (stop_at >= 0 && k == stop_at) begin
        check("R11 hv low in stop", int'(hv_en), 0);
        check("R11 enable kept in stop", int'(pgm_on), 1);
      end
      @(negedge clk);
    end
    stop_in = 1'b0;
  endtask

  task automatic apply_model(input int a, input logic [15:0] d, input logic w,
                             input logic er, input int sz, input string req);
    int lo, hi;
    lo = a - 1; hi = a + 2;
    if (!er) begin
      model[a] = model[a] & d[7:0];
      if (w && (a % 2 == 0)) model[a+1] = model[a+1] & d[15:8];
    end else if (sz == 0) begin
      model[a] = 8'hFF;
    end else if (sz == 1) begin
      model[a] = 8'hFF;
      if (a % 2 == 0) model[a+1] = 8'hFF;
    end else if (sz == 2) begin
      int s;
      s = a - (a % 32);
      for (int i = s; i < s + 32; i++) model[i] = 8'hFF;
      lo = s - 1; hi = s + 32;
    end else begin
      for (int i = 0; i < NB; i++) model[i] = 8'hFF;
      lo = 0; hi = NB - 1;
    end
    if (lo < 0) lo = 0;
    if (hi > NB - 1) hi = NB - 1;
    for (int i = lo; i <= hi; i++) expect_byte(i, int'(model[i]), req);
    drain();
  endtask

  task automatic full_op(input int a, input logic [15:0] d, input logic w, input logic er,
                         input int sz, input int t, input int stop_at, input int stop_len,
                         input string req);
    int n;
    arm_op(a, d, w, er, sz, t, req);
    wait_done(stop_at, stop_len, n);
    check({req, "/R7 hv cycles"}, n, t + 1);
    check({req, "/R7 done pulse"}, int'(op_done), 1);
    check({req, "/R7 enable cleared"}, int'(pgm_on), 0);
    apply_model(a, d, w, er, sz, req);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 hv", int'(hv_en), 0);
    check("R1 enable", int'(pgm_on), 0);
    check("R1 done", int'(op_done), 0);
    expect_byte(0, 8'hFF, "R1");
    expect_byte(383, 8'hFF, "R1");
    expect_byte(767, 8'hFF, "R1");
    expect_byte(800, 8'h00, "R13 read");
    drain();

    // R2 interlock refusals
    reg_write(1'b0, 16'h0000); reg_write(1'b0, 16'h0001); #1;
    check("R2 no latch", int'(pgm_on), 0);
    reg_write(1'b0, 16'h0002); reg_write(1'b0, 16'h0003); #1;
    check("R2 nothing captured", int'(pgm_on) | int'(hv_en), 0);
    reg_write(1'b0, 16'h0002); arr_write(7, 16'h0000, 1'b0); reg_write(1'b0, 16'h0001); #1;
    check("R2 latch dropped", int'(pgm_on), 0);
    expect_byte(7, 8'hFF, "R2 array");
    drain();

    // R13 out-of-range capture
    reg_write(1'b0, 16'h0000); reg_write(1'b0, 16'h0002);
    arr_write(800, 16'h0000, 1'b0); reg_write(1'b0, 16'h0003); #1;
    check("R13 not captured", int'(pgm_on), 0);

    full_op(5, 16'h003C, 1'b0, 1'b0, 0, 3, -1, 0, "R4 byte");
    full_op(5, 16'h00F0, 1'b0, 1'b0, 0, 0, -1, 0, "R4 and");
    full_op(10, 16'hA55A, 1'b1, 1'b0, 0, 2, -1, 0, "R5 word");
    full_op(21, 16'h1234, 1'b1, 1'b0, 0, 1, -1, 0, "R6 misaligned");
    full_op(33, 16'h0011, 1'b0, 1'b0, 0, 7, -1, 0, "R7 long");
    full_op(5, 16'h0000, 1'b0, 1'b1, 0, 1, -1, 0, "R8 byte erase");
    full_op(10, 16'h0000, 1'b0, 1'b1, 1, 1, -1, 0, "R8 word erase");

    full_op(63, 16'h0001, 1'b0, 1'b0, 0, 0, -1, 0, "R9 setup");
    full_op(70, 16'h0002, 1'b0, 1'b0, 0, 0, -1, 0, "R9 setup");
    full_op(95, 16'h0004, 1'b0, 1'b0, 0, 0, -1, 0, "R9 setup");
    full_op(96, 16'h0008, 1'b0, 1'b0, 0, 0, -1, 0, "R9 setup");
    full_op(77, 16'h0000, 1'b0, 1'b1, 2, 2, -1, 0, "R9 row erase");

    full_op(200, 16'h0055, 1'b0, 1'b0, 0, 6, 2, 8, "R11 stop");

    // R3: writes during an operation held by stop are ignored
    begin
      int n;
      arm_op(300, 16'h000F, 1'b0, 1'b0, 0, 4, "R3");
      stop_in = 1'b1;
      reg_write(1'b0, 16'h001F);
      arr_write(301, 16'h0000, 1'b0);
      #1;
      check("R3 enable kept", int'(pgm_on), 1);
      wait_done(-1, 0, n);
      check("R3/R7 hv cycles", n, 5);
      apply_model(300, 16'h000F, 1'b0, 1'b0, 0, "R3 fields ignored");
      expect_byte(33, int'(model[33]), "R3 no bulk");
      drain();
    end

    // R12: abort by clearing the enable bit
    arm_op(400, 16'h0000, 1'b0, 1'b0, 0, 20, "R12");
    repeat (3) @(negedge clk);
    reg_write(1'b0, 16'h0002); #1;
    check("R12 enable cleared", int'(pgm_on), 0);
    check("R12 hv low", int'(hv_en), 0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk); #1;
        if (op_done) seen++;
      end
      check("R12 no done", seen, 0);
    end
    expect_byte(400, 8'hFF, "R12 array");
    drain();

    full_op(600, 16'h0000, 1'b0, 1'b1, 3, 1, -1, 0, "R10 bulk");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule